// File: doc/BRIEF.md
# Two-Stage CIC Interpolator with Shared Scaling

This block multiplies the sample rate of a complex (I/Q) baseband stream by L5·L2 using two integrator-comb interpolators in series. The first section is fifth order with factor L5; the second is second order with factor L2. Each section runs its differentiators at its own input rate and its integrators at its output rate, with zero insertion between them. Because the pair has a baseband gain of L5^4·L2, a single right shift of 0 to 25 bits is applied to every sample as it enters. The net gain is therefore L5^4·L2·2^-scale.

The high rate is set from outside by a clock-enable. Every enable produces one output sample, and a new low-rate sample is taken on every (L5·L2)-th enable. Low-rate samples arrive with a valid strobe. The most recent one is held until its slot comes up, or it is used directly if it arrives in the same cycle as the slot. The output is 18 bits per rail, taken from the full-precision result.

Top module: `cic_interp_iq`

## Requirements
- R1: The factors are written as L5−1 on `l5_m1_i` and L2−1 on `l2_m1_i`, each 8 bits unsigned. `scale_i` is a 5-bit shift count in bits. All three are held steady while the block runs.
- R2: While `rst_ni` is low, `out_valid_o`, `out_i_o` and `out_q_o` are all zero.
- R3: `out_valid_o` is high in exactly the cycles that follow a cycle with `out_en_i` high.
- R4: Enables are numbered t = 0, 1, … from reset. Slot j falls on enable t = j·L5·L2. The sample used in a slot is the one on `in_i_i`/`in_q_i` when `in_valid_i` is high in that same cycle. Otherwise it is the last sample presented with `in_valid_i` high, or zero if none has been presented. Data with `in_valid_i` low is ignored.
- R5: The result visible in the cycle after enable t is y_t = Σ_m s_m·g2[t−1−(m+1)·L2], where s_m = Σ_j X_j·g5[m−4−j·L5] and X_j = x_j·2^(25−scale). Here g5 and g2 are the coefficients of (1+z^−1+…+z^−(L−1)) raised to the fifth and second power. Such an impulse response is symmetric, so the filter is linear phase.
- R6: A constant input c settles to floor(c·L5^4·L2 / 2^scale) on each rail.
- R7: Each 18-bit output is bits 42..25 of y_t in two's complement. This is floor(y_t/2^25) wrapped modulo 2^18, and the wrap also happens when the scaled gain is too large.
- R8: With L5 = L2 = 1, the output after enable t is x >>> scale of the sample from enable t−6, and zero for t < 6.
- R9: In a cycle with `out_en_i` low, `out_i_o` and `out_q_o` do not change in the next cycle.
- R10: A `scale_i` above 25 behaves exactly as 25.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l5_m1_i | input | 8 | First-section factor minus one |
| l2_m1_i | input | 8 | Second-section factor minus one |
| scale_i | input | 5 | Right-shift count, 0..25 |
| in_valid_i | input | 1 | Low-rate sample strobe |
| in_i_i | input | 16 | In-phase input, two's complement |
| in_q_i | input | 16 | Quadrature input, two's complement |
| out_en_i | input | 1 | High-rate enable, one output per pulse |
| out_valid_o | output | 1 | New output present |
| out_i_o | output | 18 | In-phase output |
| out_q_o | output | 18 | Quadrature output |

## Verification
The assertions check on every cycle that the outputs are cleared in reset, that `out_valid_o` tracks the enable one cycle later, and that the outputs hold still when no enable is given. The following can only be shown by the bench's sweeps over small factor and shift settings, compared against a convolution model of the two sections:
- the numeric response, including the fixed latency of four first-section steps and one second-section step;
- slot timing and last-sample-wins holding;
- output wrap at zero shift;
- the clamp of oversized shift values.

// File: rtl/cic_pkg.sv
package cic_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SCALE_MAX = 25;
  localparam int SH_W      = 5;

  function automatic logic [SH_W-1:0] clamp_scale(input logic [SH_W-1:0] s);
    return (s > SH_W'(SCALE_MAX)) ? SH_W'(SCALE_MAX) : s;
  endfunction
endpackage

// File: rtl/cic_in_scale.sv
module cic_in_scale #(
  parameter int IN_W   = 16,
  parameter int W      = 43,
  parameter int SH_MAX = 25,
  parameter int SH_W   = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [IN_W-1:0] din_i,
  input  logic [SH_W-1:0] shift_i,
  output logic [W-1:0]    dout_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [IN_W-1:0]     hold_q;
  logic [IN_W-1:0]     src;
  logic signed [W-1:0] ext;
  logic signed [W-1:0] up;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_q <= '0;
    else if (load_i) hold_q <= din_i;
  end

  // same-cycle sample bypasses the hold register
  assign src    = load_i ? din_i : hold_q;
  assign ext    = {{(W-IN_W){src[IN_W-1]}}, src};
  assign up     = ext <<< SH_MAX;
  assign dout_o = up >>> shift_i;
endmodule

// File: rtl/cic_rate_ctl.sv
module cic_rate_ctl #(
  parameter int FACT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [FACT_W-1:0] l5_m1_i,
  input  logic [FACT_W-1:0] l2_m1_i,
  output logic              s1_step_o,
  output logic              s1_load_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [FACT_W-1:0] p2_q, p5_q;

  assign s1_step_o = en_i && (p2_q == '0);
  assign s1_load_o = s1_step_o && (p5_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p2_q <= '0;
      p5_q <= '0;
    end else begin
      if (en_i)      p2_q <= (p2_q >= l2_m1_i) ? '0 : p2_q + 1'b1;
      if (s1_step_o) p5_q <= (p5_q >= l5_m1_i) ? '0 : p5_q + 1'b1;
    end
  end
endmodule

// File: rtl/cic_sect.sv
module cic_sect #(
  parameter int ORDER = 5,
  parameter int W     = 43,
  parameter int DO_W  = 43
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lo_en_i,
  input  logic            hi_en_i,
  input  logic [W-1:0]    din_i,
  output logic [DO_W-1:0] dout_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [ORDER:0][W-1:0]   diff;
  logic [ORDER-1:0][W-1:0] dly_q;
  logic [ORDER-1:0][W-1:0] acc_q;
  logic [W-1:0]            inj;

  always_comb begin
    diff[0] = din_i;
    for (int k = 0; k < ORDER; k++) diff[k+1] = diff[k] - dly_q[k];
  end

  // zero insertion between low-rate combs and high-rate integrators
  assign inj = lo_en_i ? diff[ORDER] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q <= '0;
      acc_q <= '0;
    end else begin
      if (lo_en_i)
        for (int k = 0; k < ORDER; k++) dly_q[k] <= diff[k];
      if (hi_en_i) begin
        acc_q[0] <= acc_q[0] + inj;
        for (int k = 1; k < ORDER; k++) acc_q[k] <= acc_q[k] + acc_q[k-1];
      end
    end
  end

  assign dout_o = acc_q[ORDER-1][W-1 -: DO_W];
endmodule

// File: rtl/cic_interp_iq.sv
module cic_interp_iq
  import cic_pkg::*;
#(
  parameter int IN_W   = 16,
  parameter int OUT_W  = 18,
  parameter int FACT_W = 8,
  parameter int ORD_A  = 5,
  parameter int ORD_B  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FACT_W-1:0] l5_m1_i,
  input  logic [FACT_W-1:0] l2_m1_i,
  input  logic [SH_W-1:0]   scale_i,
  input  logic              in_valid_i,
  input  logic [IN_W-1:0]   in_i_i,
  input  logic [IN_W-1:0]   in_q_i,
  input  logic              out_en_i,
  output logic              out_valid_o,
  output logic [OUT_W-1:0]  out_i_o,
  output logic [OUT_W-1:0]  out_q_o
);
  timeunit 1ns;
  timeprecision 1ps;

  // modular arithmetic: one width holds every output bit plus the shift range
  localparam int ACC_W = OUT_W + SCALE_MAX;
  localparam int N_CH  = 2;

  logic [SH_W-1:0]             sh;
  logic                        s1_step, s1_load;
  logic [N_CH-1:0][IN_W-1:0]   din;
  logic [N_CH-1:0][OUT_W-1:0]  dout;

  assign sh  = clamp_scale(scale_i);
  assign din = {in_q_i, in_i_i};

  cic_rate_ctl #(.FACT_W(FACT_W)) i_rate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (out_en_i),
    .l5_m1_i  (l5_m1_i),
    .l2_m1_i  (l2_m1_i),
    .s1_step_o(s1_step),
    .s1_load_o(s1_load)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic [ACC_W-1:0] x_s;
    logic [ACC_W-1:0] s1_q;

    cic_in_scale #(.IN_W(IN_W), .W(ACC_W), .SH_MAX(SCALE_MAX), .SH_W(SH_W)) i_in (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (in_valid_i),
      .din_i  (din[ch]),
      .shift_i(sh),
      .dout_o (x_s)
    );

    cic_sect #(.ORDER(ORD_A), .W(ACC_W), .DO_W(ACC_W)) i_st_a (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lo_en_i(s1_load),
      .hi_en_i(s1_step),
      .din_i  (x_s),
      .dout_o (s1_q)
    );

    cic_sect #(.ORDER(ORD_B), .W(ACC_W), .DO_W(OUT_W)) i_st_b (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lo_en_i(s1_step),
      .hi_en_i(out_en_i),
      .din_i  (s1_q),
      .dout_o (dout[ch])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_valid_o <= 1'b0;
    else         out_valid_o <= out_en_i;
  end

  assign out_i_o = dout[0];
  assign out_q_o = dout[1];
endmodule

// File: rtl/cic_interp_iq_chk.sv
module cic_interp_iq_chk #(
  parameter int OUT_W = 18
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             out_en_i,
  input logic             out_valid_o,
  input logic [OUT_W-1:0] out_i_o,
  input logic [OUT_W-1:0] out_q_o
);
  timeunit 1ns;
  timeprecision 1ps;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r2_reset_clear: assert (!out_valid_o && out_i_o == '0 && out_q_o == '0)
        else $error("R2 outputs not clear in reset");
    end
  end

  a_r3_valid_follows_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_i |=> out_valid_o);

  a_r3_no_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_i |=> !out_valid_o);

  a_r9_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_i |=> ($stable(out_i_o) && $stable(out_q_o)));
endmodule

bind cic_interp_iq cic_interp_iq_chk #(.OUT_W(OUT_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .out_en_i   (out_en_i),
  .out_valid_o(out_valid_o),
  .out_i_o    (out_i_o),
  .out_q_o    (out_q_o)
);

// File: tb/test_cic_interp_iq.sv
module test_cic_interp_iq;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic [7:0]  l5_m1 = '0, l2_m1 = '0;
  logic [4:0]  scale = '0;
  logic        in_valid = 1'b0, out_en = 1'b0;
  logic [15:0] in_i = '0, in_q = '0;
  logic        out_valid;
  logic [17:0] out_i, out_q;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  longint xi[32], xq[32];
  longint s1i[256], s1q[256];
  int     hb[2][64];
  int     nb[2];
  logic [17:0] oi[256], oq[256];

  always #2.5 clk = ~clk;

  cic_interp_iq i_cic_interp_iq (
    .clk_i(clk), .rst_ni(rst_ni), .l5_m1_i(l5_m1), .l2_m1_i(l2_m1), .scale_i(scale),
    .in_valid_i(in_valid), .in_i_i(in_i), .in_q_i(in_q), .out_en_i(out_en),
    .out_valid_o(out_valid), .out_i_o(out_i), .out_q_o(out_q)
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // coefficients of (1+z^-1+...+z^-(L-1))^ord
  task automatic make_box(int idx, int L, int ord);
    int tmp[64];
    nb[idx] = 1;
    for (int i = 0; i < 64; i++) hb[idx][i] = 0;
    hb[idx][0] = 1;
    for (int r = 0; r < ord; r++) begin
      for (int i = 0; i < 64; i++) tmp[i] = 0;
      for (int i = 0; i < nb[idx] + L - 1; i++)
        for (int d = 0; d < L; d++)
          if (i - d >= 0 && i - d < nb[idx]) tmp[i] += hb[idx][i-d];
      nb[idx] = nb[idx] + L - 1;
      for (int i = 0; i < 64; i++) hb[idx][i] = tmp[i];
    end
  endtask

  task automatic run_cfg(int l5, int l2, int s, int gap, bit early, bit dc, string tag);
    int se  = (s > 25) ? 25 : s;
    int per = l5 * l2;
    int ns  = dc ? 20 : 6;
    int nj  = ns + 8;
    int tt  = nj * per;
    longint yi, yq, ei, eq;
    logic [17:0] li, lq;
    for (int j = 0; j < nj; j++) begin
      if (j >= ns) begin xi[j] = 0; xq[j] = 0; end
      else if (dc) begin xi[j] = 1000; xq[j] = -1000; end
      else if (j == 0) begin xi[j] = 32767; xq[j] = -32768; end
      else begin
        xi[j] = longint'($signed(16'($urandom_range(0, 65535))));
        xq[j] = longint'($signed(16'($urandom_range(0, 65535))));
      end
    end
    @(negedge clk);
    rst_ni = 1'b0; out_en = 1'b0; in_valid = 1'b0;
    l5_m1 = 8'(l5 - 1); l2_m1 = 8'(l2 - 1); scale = 5'(s);
    @(negedge clk);
    chk(!out_valid && out_i == 0 && out_q == 0, "R2 reset outputs", longint'(out_i), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int t = 0; t < tt; t++) begin
      bit slot = (t % per == 0);
      int j = t / per;
      if (slot && early) begin
        in_valid = 1'b1; in_i = ~16'(xi[j]); in_q = ~16'(xq[j]);   // decoy, superseded (R4)
        @(posedge clk); @(negedge clk);
        in_i = 16'(xi[j]); in_q = 16'(xq[j]);
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0; in_i = 16'h5a5a; in_q = 16'ha5a5;
      end else if (slot) begin
        in_valid = 1'b1; in_i = 16'(xi[j]); in_q = 16'(xq[j]);
      end else begin
        in_valid = 1'b0; in_i = ~16'(xi[j]); in_q = 16'h7fff;       // ignored without valid (R4)
      end
      out_en = 1'b1;
      @(posedge clk); @(negedge clk);
      out_en = 1'b0; in_valid = 1'b0;
      chk(out_valid, "R3 valid after enable", longint'(out_valid), 1);
      oi[t] = out_i; oq[t] = out_q;
      for (int g = 0; g < gap; g++) begin
        in_valid = g[0]; in_i = 16'h1234; in_q = 16'h4321;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        chk(!out_valid, "R3 no valid when idle", longint'(out_valid), 0);
        chk(out_i == oi[t] && out_q == oq[t], "R9 hold when idle",
            longint'($signed(out_i)), longint'($signed(oi[t])));
      end
    end
    if (early) begin
      // a lone strobe after the last slot must not disturb what was consumed
      in_valid = 1'b1; in_i = 16'h7777; @(posedge clk); @(negedge clk); in_valid = 1'b0;
    end
    make_box(0, l5, 5);
    make_box(1, l2, 2);
    for (int m = 0; m <= tt; m++) begin
      s1i[m] = 0; s1q[m] = 0;
      for (int j = 0; j < nj; j++) begin
        int k = m - 4 - j * l5;
        if (k >= 0 && k < nb[0]) begin
          s1i[m] += xi[j] * (longint'(1) << (25 - se)) * hb[0][k];
          s1q[m] += xq[j] * (longint'(1) << (25 - se)) * hb[0][k];
        end
      end
    end
    for (int t = 0; t < tt; t++) begin
      yi = 0; yq = 0;
      for (int m = 0; m <= tt; m++) begin
        int k = t - 1 - (m + 1) * l2;
        if (k >= 0 && k < nb[1]) begin
          yi += s1i[m] * hb[1][k];
          yq += s1q[m] * hb[1][k];
        end
      end
      ei = yi >>> 25; eq = yq >>> 25;
      li = ei[17:0];  lq = eq[17:0];
      chk(oi[t] == li, tag, longint'($signed(oi[t])), longint'($signed(li)));
      chk(oq[t] == lq, tag, longint'($signed(oq[t])), longint'($signed(lq)));
      if (l5 == 1 && l2 == 1) begin
        longint pi = (t >= 6) ? (xi[t-6] >>> se) : 0;
        chk($signed(oi[t]) == pi, "R8 unit factors pass-through", longint'($signed(oi[t])), pi);
      end
    end
    if (dc) begin
      chk($signed(oi[90]) == 1265,  "R6 dc gain I", longint'($signed(oi[90])), 1265);
      chk($signed(oq[90]) == -1266, "R6 dc gain Q", longint'($signed(oq[90])), -1266);
    end
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    for (int a = 1; a <= 4; a++)
      for (int b = 1; b <= 3; b++) begin
        if (a == 4 && b == 3) run_cfg(a, b, 0, 0, 0, 0, "R7 wrap at zero shift");
        else run_cfg(a, b, (a * 7 + b * 5) % 26, 0, 0, 0, "R5 R1 sweep response");
      end
    run_cfg(2, 2, 3, 2, 1, 0, "R4 early and held samples");
    run_cfg(3, 1, 9, 1, 0, 0, "R4 R9 paced enables");
    run_cfg(4, 2, 31, 0, 0, 0, "R10 shift clamp");
    run_cfg(3, 2, 7, 0, 0, 1, "R6 dc response");
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule